// File: doc/BRIEF.md
# Four-Lane Packed Multiply-Accumulate Filter Datapath

This block is a small vector datapath for FIR-style filtering. It keeps its operands in quad registers, each holding four 16-bit signed elements, and does all four lanes of an operation in one clock. A separate four-lane accumulator with 40-bit lanes collects products. A fixed group of four quad registers forms a 16-sample delay line. Each shift pushes one new sample in at the newest end and drops the oldest sample.

A controller sends one instruction per cycle over a valid/ready opcode interface. A typical filter pass loads the coefficients once. For each group of four outputs it then repeats three steps: broadcast one coefficient lane into a scratch register, multiply-accumulate that scratch register against one delay-line register, and shift in the next input sample. At the end it writes the accumulator out as one saturated quad. Because the broadcast value multiplies four adjacent samples at once, four neighbouring filter outputs build up in parallel. Input samples arrive on a valid-qualified port and are consumed only by the shift instruction. Results leave on a valid-qualified port.

Opcodes on `op_code`: 0 idle, 1 load quad, 2 broadcast, 3 multiply-accumulate, 4 shift sample, 5 write result, 6 clear accumulator, 7 load accumulator. Codes 8 to 15 do nothing. In every quad, lane 0 sits in bits [15:0] and lane i in bits [16i+15:16i]. There are nine quad registers, numbered 0 to 8. Registers 4 to 7 form the delay line. The newest sample is lane 3 of register 7. Position p = 4*(reg-4)+lane counts from the oldest (p=0, lane 0 of register 4) to the newest (p=15).

Top module: `qmac_unit`

## Requirements
- R1: After synchronous reset, all quad registers and all accumulator lanes are zero, `res_valid` is 0 and `res_quad` is 0.
- R2: Opcode 1 writes `op_quad` into register `op_dst`, with lane 0 taken from bits [15:0].
- R3: Opcode 2 writes four copies of lane `op_lane` of register `op_srca` into register `op_dst`.
- R4: Opcode 3 adds the signed product of lane i of register `op_srca` and lane i of register `op_srcb` into accumulator lane i, for all four lanes in the same cycle.
- R5: Each accumulator lane is 40 bits wide, so sixteen products of -32768 by -32768 add to 2^34 without wrapping.
- R6: Opcode 4 moves every delay-line element from position p+1 to position p, drops position 0, and writes `samp_data` into position 15.
- R7: While opcode 4 is presented and `samp_valid` is 0, `op_ready` and `samp_ready` are 0 and the delay line is unchanged. `samp_ready` is 1 only in the cycle where a shift is accepted.
- R8: Opcode 5 drives `res_valid` to 1 for one cycle after the accepting edge. In that cycle each lane of `res_quad` is the matching accumulator lane saturated to the range [-32768, 32767]. `res_quad` holds its value when no write result is accepted.
- R9: Opcode 6 sets all accumulator lanes to zero. Opcode 7 sets accumulator lane i to the sign-extended lane i of `op_quad`.
- R10: While `op_valid` is 0, no register, accumulator lane or output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction present |
| op_ready | output | 1 | Instruction accepted this cycle when op_valid is 1 |
| op_code | input | 4 | Opcode |
| op_dst | input | 4 | Destination register index |
| op_srca | input | 4 | First source register index |
| op_srcb | input | 4 | Second source register index |
| op_lane | input | 2 | Lane index for broadcast |
| op_quad | input | 64 | Immediate quad for load quad and load accumulator |
| samp_valid | input | 1 | New sample available |
| samp_data | input | 16 | New signed sample |
| samp_ready | output | 1 | Sample consumed this cycle |
| res_valid | output | 1 | Result quad valid |
| res_quad | output | 64 | Saturated accumulator quad |

## Verification
The delay line cannot be read directly. Its contents are only visible through the accumulator, which makes the shift ordering (R6) the hardest thing to observe from the ports. The stimulus first loads a quad of ones. For each delay-line register it then clears the accumulator, multiplies that register by the ones quad, and writes the result out, so each register shows up lane by lane after 16 and after 17 shifts. The stall case uses the same readback: the bench holds a shift with no sample for several cycles and then confirms the newest register is unchanged. Accumulator width is probed by driving sixteen maximal products into every lane and expecting positive saturation rather than a wrapped value.

// File: rtl/qmac_pkg.sv
package qmac_pkg;

    localparam int LANES   = 4;
    localparam int ELEM_W  = 16;
    localparam int ACC_W   = 40;
    localparam int NREG    = 9;
    localparam int DL_BASE = 4;
    localparam int DL_REGS = 4;
    localparam int REG_AW  = 4;
    localparam int LANE_AW = $clog2(LANES);
    localparam int QUAD_W  = LANES * ELEM_W;

    typedef logic signed [ELEM_W-1:0] elem_t;
    typedef elem_t [LANES-1:0]         quad_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [3:0] {
        OP_IDLE   = 4'd0,
        OP_LDQ    = 4'd1,
        OP_BCAST  = 4'd2,
        OP_MAC    = 4'd3,
        OP_SHIFT  = 4'd4,
        OP_WRES   = 4'd5,
        OP_ACLR   = 4'd6,
        OP_ALD    = 4'd7
    } opcode_t;

    // Clamp a wide accumulator lane to the element range.
    function automatic elem_t clamp_elem(acc_t v);
        logic [ACC_W-ELEM_W:0] top;
        top = v[ACC_W-1:ELEM_W-1];
        if (top == '0 || top == '1)
            return v[ELEM_W-1:0];
        else if (v[ACC_W-1])
            return {1'b1, {(ELEM_W-1){1'b0}}};
        else
            return {1'b0, {(ELEM_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/qmac_regfile.sv
module qmac_regfile
    import qmac_pkg::*;
#(
    parameter int N_REG  = NREG,
    parameter int DLB    = DL_BASE,
    parameter int DLN    = DL_REGS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_idx,
    input  quad_t             wr_quad,
    input  logic              sh_en,
    input  elem_t             sh_elem,
    output quad_t             regs_o [N_REG]
);
    localparam int DL_ELEMS = DLN * LANES;

    quad_t regs_q [N_REG];
    elem_t dl_next [DL_ELEMS];

    // Shifted delay line: position p takes position p+1, newest takes the sample.
    always_comb begin
        for (int p = 0; p < DL_ELEMS; p++) begin
            if (p == DL_ELEMS - 1)
                dl_next[p] = sh_elem;
            else
                dl_next[p] = regs_q[DLB + (p + 1) / LANES][(p + 1) % LANES];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < N_REG; r++)
                regs_q[r] <= '0;
        end else if (sh_en) begin
            for (int p = 0; p < DL_ELEMS; p++)
                regs_q[DLB + p / LANES][p % LANES] <= dl_next[p];
        end else if (wr_en && (wr_idx < REG_AW'(N_REG))) begin
            regs_q[wr_idx] <= wr_quad;
        end
    end

    always_comb begin
        for (int r = 0; r < N_REG; r++)
            regs_o[r] = regs_q[r];
    end

endmodule

// File: rtl/qmac_lane.sv
module qmac_lane
    import qmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  ld,
    input  elem_t ld_val,
    input  logic  mac,
    input  elem_t mul_a,
    input  elem_t mul_b,
    output elem_t sat_o
);
    acc_t acc_q;
    acc_t prod;

    assign prod  = acc_t'(mul_a) * acc_t'(mul_b);
    assign sat_o = clamp_elem(acc_q);

    always_ff @(posedge clk) begin
        if (rst || clr)
            acc_q <= '0;
        else if (ld)
            acc_q <= acc_t'(ld_val);
        else if (mac)
            acc_q <= acc_q + prod;
    end

endmodule

// File: rtl/qmac_unit.sv
module qmac_unit
    import qmac_pkg::*;
#(
    parameter int N_REG = NREG,
    parameter int DLB   = DL_BASE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                op_valid,
    output logic                op_ready,
    input  logic [3:0]          op_code,
    input  logic [REG_AW-1:0]   op_dst,
    input  logic [REG_AW-1:0]   op_srca,
    input  logic [REG_AW-1:0]   op_srcb,
    input  logic [LANE_AW-1:0]  op_lane,
    input  logic [QUAD_W-1:0]   op_quad,
    input  logic                samp_valid,
    input  logic [ELEM_W-1:0]   samp_data,
    output logic                samp_ready,
    output logic                res_valid,
    output logic [QUAD_W-1:0]   res_quad
);
    opcode_t op;
    logic    fire;
    quad_t   regs [N_REG];
    quad_t   qa, qb, bcast, imm, sat_q;
    logic    wr_en;
    quad_t   wr_quad;

    assign op       = opcode_t'(op_code);
    assign op_ready = !(op == OP_SHIFT && !samp_valid);
    assign fire     = op_valid && op_ready;
    assign samp_ready = op_valid && (op == OP_SHIFT) && samp_valid;
    assign imm      = quad_t'(op_quad);

    function automatic quad_t rd(input quad_t rf [N_REG], input logic [REG_AW-1:0] idx);
        return (idx < REG_AW'(N_REG)) ? rf[idx] : '0;
    endfunction

    always_comb begin
        qa = rd(regs, op_srca);
        qb = rd(regs, op_srcb);
        for (int l = 0; l < LANES; l++)
            bcast[l] = qa[op_lane];
    end

    assign wr_en   = fire && (op == OP_LDQ || op == OP_BCAST);
    assign wr_quad = (op == OP_LDQ) ? imm : bcast;

    qmac_regfile #(.N_REG(N_REG), .DLB(DLB), .DLN(DL_REGS)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (op_dst),
        .wr_quad (wr_quad),
        .sh_en   (fire && op == OP_SHIFT),
        .sh_elem (elem_t'(samp_data)),
        .regs_o  (regs)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        qmac_lane u_lane (
            .clk    (clk),
            .rst    (rst),
            .clr    (fire && op == OP_ACLR),
            .ld     (fire && op == OP_ALD),
            .ld_val (imm[g]),
            .mac    (fire && op == OP_MAC),
            .mul_a  (qa[g]),
            .mul_b  (qb[g]),
            .sat_o  (sat_q[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_quad  <= '0;
        end else begin
            res_valid <= fire && op == OP_WRES;
            if (fire && op == OP_WRES)
                res_quad <= sat_q;
        end
    end

endmodule

// File: rtl/qmac_unit_chk.sv
module qmac_unit_chk
    import qmac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic              op_ready,
    input logic [3:0]        op_code,
    input logic              samp_valid,
    input logic              samp_ready,
    input logic              res_valid,
    input logic [QUAD_W-1:0] res_quad
);
    // R1: reset clears the result port
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!res_valid && res_quad == '0));

    // R7: no sample taken unless one is offered
    a_r7_no_phantom_sample: assert property (@(posedge clk) disable iff (rst)
        !samp_valid |-> !samp_ready);

    // R7: a consumed sample implies the instruction was accepted
    a_r7_take_implies_ready: assert property (@(posedge clk) disable iff (rst)
        samp_ready |-> op_ready);

    // R10: no sample consumption without an instruction
    a_r10_idle_no_take: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !samp_ready);

    // R8: a result pulse follows an accepted write-result instruction
    a_r8_valid_source: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(op_valid && op_ready && op_code == 4'd5));

    // R8: result quad holds when no write-result is accepted
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !(op_valid && op_code == 4'd5) |=> $stable(res_quad));

endmodule

bind qmac_unit qmac_unit_chk u_chk (.*);

// File: tb/qmac_unit_test.sv
`timescale 1ns/1ps
module qmac_unit_test;
    import qmac_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              op_valid;
    logic              op_ready;
    logic [3:0]        op_code;
    logic [REG_AW-1:0] op_dst, op_srca, op_srcb;
    logic [LANE_AW-1:0] op_lane;
    logic [QUAD_W-1:0] op_quad;
    logic              samp_valid;
    logic [ELEM_W-1:0] samp_data;
    logic              samp_ready;
    logic              res_valid;
    logic [QUAD_W-1:0] res_quad;

    always #2 clk = ~clk;

    qmac_unit uut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct packed {
        logic [3:0]  op;
        logic [3:0]  dst;
        logic [3:0]  a;
        logic [3:0]  b;
        logic [1:0]  lane;
        logic [63:0] data;
        logic        chk;
        logic [63:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{4'd1, 4'd8, 4'd0, 4'd0, 2'd0, 64'h0001_0001_0001_0001, 1'b0, 64'h0},
        '{4'd1, 4'd0, 4'd0, 4'd0, 2'd0, 64'h8000_0064_FFFE_0003, 1'b0, 64'h0},
        '{4'd6, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0,                   1'b0, 64'h0},
        '{4'd3, 4'd0, 4'd0, 4'd8, 2'd0, 64'h0,                   1'b0, 64'h0},
        '{4'd5, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0,                   1'b1, 64'h8000_0064_FFFE_0003},
        '{4'd1, 4'd1, 4'd0, 4'd0, 2'd0, 64'h000B_FFF7_0007_0005, 1'b0, 64'h0},
        '{4'd2, 4'd2, 4'd1, 4'd0, 2'd2, 64'h0,                   1'b0, 64'h0},
        '{4'd6, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0,                   1'b0, 64'h0},
        '{4'd3, 4'd0, 4'd2, 4'd0, 2'd0, 64'h0,                   1'b0, 64'h0},
        '{4'd5, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0,                   1'b1, 64'h7FFF_FC7C_0012_FFE5},
        '{4'd7, 4'd0, 4'd0, 4'd0, 2'd0, 64'h8000_7FFF_FFF6_000A, 1'b0, 64'h0},
        '{4'd3, 4'd0, 4'd8, 4'd8, 2'd0, 64'h0,                   1'b0, 64'h0},
        '{4'd5, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0,                   1'b1, 64'h8001_7FFF_FFF7_000B}
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one instruction for one edge; returns at the following negedge.
    task automatic issue(input logic [3:0] op, input logic [3:0] d, input logic [3:0] a,
                         input logic [3:0] b, input logic [1:0] ln, input logic [63:0] q);
        op_valid = 1'b1; op_code = op; op_dst = d; op_srca = a; op_srcb = b;
        op_lane = ln; op_quad = q;
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0;
    endtask

    task automatic shift_in(input logic [15:0] s);
        samp_valid = 1'b1; samp_data = s;
        issue(4'd4, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        samp_valid = 1'b0;
    endtask

    // Readback through the accumulator: reg * ones quad (register 8).
    task automatic read_reg(input logic [3:0] idx, input logic [63:0] exp, input string tag);
        issue(4'd6, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        issue(4'd3, 4'd0, idx, 4'd8, 2'd0, 64'h0);
        issue(4'd5, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        check(res_valid && res_quad == exp, tag, res_quad, exp);
    endtask

    function automatic logic [63:0] dl_quad(input int k, input int off);
        logic [63:0] q;
        for (int l = 0; l < 4; l++)
            q[16*l +: 16] = 16'(100 + 4*k + l + off);
        return q;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; op_code = 4'd0; op_dst = '0; op_srca = '0;
        op_srcb = '0; op_lane = '0; op_quad = '0; samp_valid = 1'b0; samp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state at the ports and in the storage
        check(!res_valid && res_quad == 64'h0, "R1 result port after reset", res_quad, 64'h0);
        check(op_ready, "R1 ready when idle", {63'h0, op_ready}, 64'h1);
        issue(4'd5, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        check(res_valid && res_quad == 64'h0, "R1 accumulator zero after reset", res_quad, 64'h0);
        issue(4'd1, 4'd8, 4'd0, 4'd0, 2'd0, 64'h0001_0001_0001_0001);
        read_reg(4'd4, 64'h0, "R1 delay register zero after reset");

        // Table walk: R2 R3 R4 R8 R9
        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].dst, TBL[i].a, TBL[i].b, TBL[i].lane, TBL[i].data);
            if (TBL[i].chk)
                check(res_valid && res_quad == TBL[i].exp,
                      $sformatf("R2/R3/R4/R8/R9 table step %0d", i), res_quad, TBL[i].exp);
        end

        // R8: result pulse lasts one cycle and the quad holds
        @(negedge clk);
        check(!res_valid, "R8 single-cycle result pulse", {63'h0, res_valid}, 64'h0);
        check(res_quad == 64'h8001_7FFF_FFF7_000B, "R8 result quad holds", res_quad,
              64'h8001_7FFF_FFF7_000B);

        // R5: sixteen maximal products saturate positive, no wrap
        issue(4'd1, 4'd0, 4'd0, 4'd0, 2'd0, 64'h8000_8000_8000_8000);
        issue(4'd6, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        for (int i = 0; i < 16; i++)
            issue(4'd3, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        issue(4'd5, 4'd0, 4'd0, 4'd0, 2'd0, 64'h0);
        check(res_valid && res_quad == 64'h7FFF_7FFF_7FFF_7FFF, "R5 wide accumulator", res_quad,
              64'h7FFF_7FFF_7FFF_7FFF);

        // R10: idle-qualified instructions do nothing
        op_valid = 1'b0; op_code = 4'd1; op_dst = 4'd0; op_quad = 64'h1234_1234_1234_1234;
        @(negedge clk);
        op_code = 4'd5;
        @(negedge clk);
        check(!res_valid, "R10 write result ignored without valid", {63'h0, res_valid}, 64'h0);
        op_code = 4'd0;
        read_reg(4'd0, 64'h8000_8000_8000_8000, "R10 load ignored without valid");

        // R6: delay line ordering after 16 and 17 shifts
        for (int i = 1; i <= 16; i++)
            shift_in(16'(100 + i));
        for (int k = 0; k < 4; k++)
            read_reg(4'(4 + k), dl_quad(k, 1), $sformatf("R6 delay reg %0d after 16", 4 + k));
        shift_in(16'd117);
        for (int k = 0; k < 4; k++)
            read_reg(4'(4 + k), dl_quad(k, 2), $sformatf("R6 delay reg %0d after 17", 4 + k));

        // R7: shift held while no sample is valid
        op_valid = 1'b1; op_code = 4'd4; samp_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            #1;
            check(!op_ready && !samp_ready, "R7 stall ready low",
                  {62'h0, op_ready, samp_ready}, 64'h0);
            @(negedge clk);
        end
        op_valid = 1'b0; op_code = 4'd0;
        read_reg(4'd7, dl_quad(3, 2), "R7 delay line unchanged during stall");
        op_valid = 1'b1; op_code = 4'd4; samp_valid = 1'b1; samp_data = 16'd500;
        #1;
        check(op_ready && samp_ready, "R7 sample accepted when valid",
              {62'h0, op_ready, samp_ready}, 64'h3);
        @(negedge clk);
        op_valid = 1'b0; op_code = 4'd0; samp_valid = 1'b0;
        read_reg(4'd7, {16'd500, 16'd117, 16'd116, 16'd115}, "R7 R6 shift after release");

        finish_run();
    end

endmodule